// File: doc/BRIEF.md
# Motor Controller SPI Register Bridge

This block sits between a host microcontroller acting as SPI master and the motor-control logic of a small robot. Every transaction, framed by chip-select low, opens with a command byte. Command 0x00 streams a status frame back to the host: a firmware version, the wheel encoder counts, a fault byte, two kicker bytes and the hall-sensor counters. Command 0x01 carries new setpoints: a 10-bit speed and a 2-bit drive mode for each wheel and for the dribbler, plus the kicker charge, chip/kick choice and kick power.

The SPI pins are brought into the system clock domain through synchronizers and oversampled, so the system clock must run well above the serial clock. Status inputs are captured as one snapshot when chip-select falls, so a multi-byte count never tears. Incoming setpoints go to a shadow store first. They reach the live outputs only when chip-select rises after a complete, well-formed frame. A frame with reserved bits set raises a sticky protocol-error flag that the host can read back.

Top module: `motor_spi_regs`

## Requirements
- R1: SPI mode 0, MSB first: MOSI is taken on the rising serial clock edge and MISO changes on the falling edge. Chip-select high at any point, even mid-byte, clears the bit and byte position, and the next transaction starts from its command byte.
- R2: The first byte of a transaction is the command, and MISO is 0 while it is shifted. For command 0x00, bytes 2 to 18 of the transaction return a 17-byte frame in this order: version 0x04; for encoders 1 to 4, the low byte then the high byte of the 16-bit count; the fault byte; kicker status; kicker voltage; hall counts 1 to 5.
- R3: Read data comes from a snapshot of the status inputs taken when chip-select asserts. Input changes during the transaction do not show in its frame.
- R4: Read-frame bytes after the 17th return 0x00.
- R5: Command 0x01 is followed by 11 data bytes. For drives 1 to 5 in turn (drive 5 is the dribbler), the first byte is speed[7:0] and the second byte holds speed[9:8] in bits [1:0] and the drive mode in bits [3:2]. In the dribbler's second byte, bit 7 is kick charge and bit 6 picks chip (1) or kick (0). The last byte is kick power. Drive i (0-based) appears on drv_speed[10i+9:10i] and drv_mode[2i+1:2i].
- R6: The live outputs change only when chip-select rises after exactly 12 whole bytes (the command plus 11 data bytes) of a write. Shorter or longer frames, or a partial trailing byte, leave every output unchanged.
- R7: A write data byte with a nonzero reserved bit sets a sticky protocol-error flag, and that frame is not committed. The reserved bits are [7:4] of each wheel's second byte and [5:4] of the dribbler's second byte. The flag is read back as bit 7 of the fault byte, whose bits [6:0] come from fault_in. Only reset clears it.
- R8: Any command other than 0x00 returns 0x00 in every byte. A command other than 0x00 or 0x01 changes no output and no flag.
- R9: After reset, all setpoint outputs are zero, the error flag is clear and MISO is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Active-low reset |
| spi_sclk | input | 1 | Serial clock from the master, idles low |
| spi_cs_n | input | 1 | Active-low chip-select framing one transaction |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |
| enc_count | input | NUM_WHEEL*16 | Encoder counts, wheel 1 in the low 16 bits |
| fault_in | input | 7 | Motor fault flags for fault byte bits [6:0] |
| kick_status | input | 8 | Kicker status byte |
| kick_volt | input | 8 | Kicker voltage byte |
| hall_count | input | NUM_HALL*8 | Hall counters, counter 1 in the low byte |
| drv_speed | output | (NUM_WHEEL+1)*10 | Committed drive speeds, wheels then dribbler |
| drv_mode | output | (NUM_WHEEL+1)*2 | Committed drive modes |
| kick_charge | output | 1 | Committed kicker charge enable |
| kick_chip | output | 1 | Committed chip (1) or kick (0) selection |
| kick_power | output | 8 | Committed kick power |

## Verification
Several properties are checked on every cycle. They cover the clearing of the shift position whenever chip-select is high, the one-cycle byte strobe, a quiet MISO during the command byte and under any non-read command, snapshot stability inside a transaction, stickiness of the error flag, and outputs held steady except at a commit. What the properties cannot show is the content of the data: the byte order of the read frame, the field packing of written speeds and modes, the exact-length commit rule and the rejection of reserved-bit violations. The bench sweeps these by running whole transactions and comparing against values it computes itself.

// File: rtl/motor_spi_pkg.sv
package motor_spi_pkg;

  localparam int BYTE_W  = 8;
  localparam int SPEED_W = 10;
  localparam int MODE_W  = 2;
  localparam int ENC_W   = 16;
  localparam int CNT_W   = 5;

  localparam logic [7:0] CMD_READ  = 8'h00;
  localparam logic [7:0] CMD_WRITE = 8'h01;

  // status frame length: version, two bytes per encoder, fault, kick status, kick volt, halls
  function automatic int read_len(input int nw, input int nh);
    return 1 + 2 * nw + 3 + nh;
  endfunction

  // whole write transaction: command, two bytes per drive (wheels + dribbler), power
  function automatic int write_len(input int nw);
    return 1 + 2 * (nw + 1) + 1;
  endfunction

  function automatic logic [SPEED_W-1:0] join_speed(input logic [7:0] lo, input logic [7:0] hi);
    return {hi[1:0], lo};
  endfunction

  function automatic logic [MODE_W-1:0] mode_field(input logic [7:0] hi);
    return hi[3:2];
  endfunction

  // reserved-bit violation for a write data byte at transaction position pos
  function automatic logic rsvd_bad(input int pos, input logic [7:0] b, input int nw);
    if (pos >= 2 && pos <= 2 * nw && (pos % 2) == 0) return |b[7:4];
    if (pos == 2 * nw + 2) return |b[5:4];
    return 1'b0;
  endfunction

endpackage

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
  import motor_spi_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk_in,
  input  logic             cs_n_in,
  input  logic             mosi_in,
  input  logic [7:0]       tx_byte,
  output logic             miso,
  output logic             byte_done,
  output logic [7:0]       rx_byte,
  output logic [CNT_W-1:0] byte_cnt,
  output logic             cs_active,
  output logic             cs_start,
  output logic             cs_end,
  output logic             bit_aligned
);

  logic [SYNC_STAGES-1:0] sclk_sync, cs_sync, mosi_sync;
  logic sclk_s, act_s, mosi_s;
  logic sclk_q, act_q;
  logic s_rise, s_fall;
  logic [2:0] bit_cnt;
  logic [6:0] rx_sr;
  logic [7:0] tx_sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_sync <= '0;
      cs_sync   <= '1;
      mosi_sync <= '0;
    end else begin
      sclk_sync <= {sclk_sync[SYNC_STAGES-2:0], sclk_in};
      cs_sync   <= {cs_sync[SYNC_STAGES-2:0], cs_n_in};
      mosi_sync <= {mosi_sync[SYNC_STAGES-2:0], mosi_in};
    end
  end

  assign sclk_s = sclk_sync[SYNC_STAGES-1];
  assign act_s  = !cs_sync[SYNC_STAGES-1];
  assign mosi_s = mosi_sync[SYNC_STAGES-1];

  assign s_rise   = sclk_s && !sclk_q;
  assign s_fall   = !sclk_s && sclk_q;
  assign cs_start = act_s && !act_q;
  assign cs_end   = !act_s && act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q    <= 1'b0;
      act_q     <= 1'b0;
      bit_cnt   <= '0;
      byte_cnt  <= '0;
      rx_sr     <= '0;
      tx_sr     <= '0;
      byte_done <= 1'b0;
      rx_byte   <= '0;
    end else begin
      sclk_q <= sclk_s;
      act_q  <= act_s;
      if (!act_s) begin
        bit_cnt   <= '0;
        byte_cnt  <= '0;
        rx_sr     <= '0;
        tx_sr     <= '0;
        byte_done <= 1'b0;
      end else begin
        byte_done <= 1'b0;
        if (byte_done && byte_cnt != '1) byte_cnt <= byte_cnt + 1'b1;
        if (s_rise) begin
          rx_sr   <= {rx_sr[5:0], mosi_s};
          bit_cnt <= bit_cnt + 1'b1;
          if (bit_cnt == 3'd7) begin
            byte_done <= 1'b1;
            rx_byte   <= {rx_sr, mosi_s};
          end
        end
        if (s_fall) begin
          if (bit_cnt == 3'd0) tx_sr <= tx_byte;
          else                 tx_sr <= {tx_sr[6:0], 1'b0};
        end
      end
    end
  end

  assign miso        = tx_sr[7];
  assign cs_active   = act_s;
  assign bit_aligned = (bit_cnt == 3'd0);

  // R1: an idle chip-select leaves no shift position and a quiet output behind
  a_r1_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !act_s |=> (bit_cnt == 3'd0 && byte_cnt == '0 && !miso));

  // R1: a completed byte is announced for a single cycle
  a_r1_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> !byte_done);

endmodule

// File: rtl/status_frame_mux.sv
module status_frame_mux
  import motor_spi_pkg::*;
#(
  parameter int         NUM_WHEEL = 4,
  parameter int         NUM_HALL  = 5,
  parameter logic [7:0] VERSION   = 8'h04
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cs_active,
  input  logic                        cs_start,
  input  logic                        cmd_is_read,
  input  logic [CNT_W-1:0]            byte_cnt,
  input  logic [NUM_WHEEL*ENC_W-1:0]  enc_count,
  input  logic [6:0]                  fault_in,
  input  logic                        proto_err,
  input  logic [7:0]                  kick_status,
  input  logic [7:0]                  kick_volt,
  input  logic [NUM_HALL*8-1:0]       hall_count,
  output logic [7:0]                  tx_byte
);

  localparam int FL        = read_len(NUM_WHEEL, NUM_HALL);
  localparam int FAULT_POS = 1 + 2 * NUM_WHEEL;
  localparam int HALL_POS  = FAULT_POS + 3;

  logic [FL*8-1:0] live_flat, snap_flat;
  logic [CNT_W-1:0] idx;

  assign live_flat[7:0] = VERSION;

  for (genvar w = 0; w < NUM_WHEEL; w++) begin : g_enc
    assign live_flat[(1 + 2*w)*8 +: 8] = enc_count[w*ENC_W +: 8];
    assign live_flat[(2 + 2*w)*8 +: 8] = enc_count[w*ENC_W + 8 +: 8];
  end

  assign live_flat[FAULT_POS*8 +: 8]     = {proto_err, fault_in};
  assign live_flat[(FAULT_POS+1)*8 +: 8] = kick_status;
  assign live_flat[(FAULT_POS+2)*8 +: 8] = kick_volt;

  for (genvar h = 0; h < NUM_HALL; h++) begin : g_hall
    assign live_flat[(HALL_POS + h)*8 +: 8] = hall_count[h*8 +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        snap_flat <= '0;
    else if (cs_start) snap_flat <= live_flat;
  end

  assign idx = byte_cnt - 1'b1;

  always_comb begin
    tx_byte = 8'h00;
    if (cmd_is_read && byte_cnt != '0 && int'(byte_cnt) <= FL)
      tx_byte = snap_flat[int'(idx)*8 +: 8];
  end

  // R3: the snapshot is frozen for the rest of the transaction
  a_r3_snap_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_active && !cs_start) |=> $stable(snap_flat));

  // R4: nothing is offered past the end of the frame
  a_r4_tail_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(byte_cnt) > FL) |-> (tx_byte == 8'h00));

endmodule

// File: rtl/write_frame_decoder.sv
module write_frame_decoder
  import motor_spi_pkg::*;
#(
  parameter int NUM_WHEEL = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         byte_done,
  input  logic [CNT_W-1:0]             byte_pos,
  input  logic [7:0]                   rx_byte,
  input  logic                         cmd_is_write,
  input  logic                         cs_end,
  input  logic                         bit_aligned,
  output logic [(NUM_WHEEL+1)*SPEED_W-1:0] drv_speed,
  output logic [(NUM_WHEEL+1)*MODE_W-1:0]  drv_mode,
  output logic                         kick_charge,
  output logic                         kick_chip,
  output logic [7:0]                   kick_power,
  output logic                         proto_err
);

  localparam int ND      = NUM_WHEEL + 1;
  localparam int WL      = write_len(NUM_WHEEL);
  localparam int DRB_HI  = 2 * ND;

  logic [WL*8-1:0] shadow;
  logic            frame_bad;
  logic            commit;
  logic            store_en;
  logic            byte_bad;

  assign store_en = byte_done && cmd_is_write && byte_pos != '0 && int'(byte_pos) < WL;
  assign byte_bad = rsvd_bad(int'(byte_pos), rx_byte, NUM_WHEEL);
  assign commit   = cs_end && cmd_is_write && int'(byte_pos) == WL && bit_aligned && !frame_bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow      <= '0;
      frame_bad   <= 1'b0;
      proto_err   <= 1'b0;
      drv_speed   <= '0;
      drv_mode    <= '0;
      kick_charge <= 1'b0;
      kick_chip   <= 1'b0;
      kick_power  <= '0;
    end else begin
      if (store_en) begin
        shadow[int'(byte_pos)*8 +: 8] <= rx_byte;
        if (byte_bad) begin
          proto_err <= 1'b1;
          frame_bad <= 1'b1;
        end
      end
      if (cs_end) frame_bad <= 1'b0;
      if (commit) begin
        for (int i = 0; i < ND; i++) begin
          drv_speed[i*SPEED_W +: SPEED_W] <= join_speed(shadow[(1 + 2*i)*8 +: 8],
                                                        shadow[(2 + 2*i)*8 +: 8]);
          drv_mode[i*MODE_W +: MODE_W]    <= mode_field(shadow[(2 + 2*i)*8 +: 8]);
        end
        kick_charge <= shadow[DRB_HI*8 + 7];
        kick_chip   <= shadow[DRB_HI*8 + 6];
        kick_power  <= shadow[(WL-1)*8 +: 8];
      end
    end
  end

  // R6: a commit coincides with the end of the transaction, after which the position is clear
  a_r6_commit_closes: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (byte_pos == '0));

  // R6: setpoints hold between commits
  a_r6_live_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable({drv_speed, drv_mode, kick_charge, kick_chip, kick_power}));

  // R7: the protocol-error flag never clears on its own
  a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err);

endmodule

// File: rtl/motor_spi_regs.sv
module motor_spi_regs
  import motor_spi_pkg::*;
#(
  parameter int         NUM_WHEEL   = 4,
  parameter int         NUM_HALL    = 5,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] VERSION     = 8'h04
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               spi_sclk,
  input  logic                               spi_cs_n,
  input  logic                               spi_mosi,
  output logic                               spi_miso,
  input  logic [NUM_WHEEL*16-1:0]            enc_count,
  input  logic [6:0]                         fault_in,
  input  logic [7:0]                         kick_status,
  input  logic [7:0]                         kick_volt,
  input  logic [NUM_HALL*8-1:0]              hall_count,
  output logic [(NUM_WHEEL+1)*10-1:0]        drv_speed,
  output logic [(NUM_WHEEL+1)*2-1:0]         drv_mode,
  output logic                               kick_charge,
  output logic                               kick_chip,
  output logic [7:0]                         kick_power
);

  logic [7:0]       tx_byte, rx_byte, cmd;
  logic [CNT_W-1:0] byte_cnt;
  logic             byte_done, cs_active, cs_start, cs_end, bit_aligned;
  logic             cmd_valid, cmd_is_read, cmd_is_write, proto_err;

  spi_shift_engine #(.SYNC_STAGES(SYNC_STAGES)) u_engine (
    .clk(clk), .rst_n(rst_n), .sclk_in(spi_sclk), .cs_n_in(spi_cs_n), .mosi_in(spi_mosi),
    .tx_byte(tx_byte), .miso(spi_miso), .byte_done(byte_done), .rx_byte(rx_byte),
    .byte_cnt(byte_cnt), .cs_active(cs_active), .cs_start(cs_start), .cs_end(cs_end),
    .bit_aligned(bit_aligned)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd       <= '0;
      cmd_valid <= 1'b0;
    end else if (!cs_active) begin
      cmd_valid <= 1'b0;
    end else if (byte_done && byte_cnt == '0) begin
      cmd       <= rx_byte;
      cmd_valid <= 1'b1;
    end
  end

  assign cmd_is_read  = cmd_valid && cmd == CMD_READ;
  assign cmd_is_write = cmd_valid && cmd == CMD_WRITE;

  status_frame_mux #(.NUM_WHEEL(NUM_WHEEL), .NUM_HALL(NUM_HALL), .VERSION(VERSION)) u_status (
    .clk(clk), .rst_n(rst_n), .cs_active(cs_active), .cs_start(cs_start),
    .cmd_is_read(cmd_is_read), .byte_cnt(byte_cnt), .enc_count(enc_count),
    .fault_in(fault_in), .proto_err(proto_err), .kick_status(kick_status),
    .kick_volt(kick_volt), .hall_count(hall_count), .tx_byte(tx_byte)
  );

  write_frame_decoder #(.NUM_WHEEL(NUM_WHEEL)) u_write (
    .clk(clk), .rst_n(rst_n), .byte_done(byte_done), .byte_pos(byte_cnt), .rx_byte(rx_byte),
    .cmd_is_write(cmd_is_write), .cs_end(cs_end), .bit_aligned(bit_aligned),
    .drv_speed(drv_speed), .drv_mode(drv_mode), .kick_charge(kick_charge),
    .kick_chip(kick_chip), .kick_power(kick_power), .proto_err(proto_err)
  );

  // R2: the command byte is shifted against a silent output
  a_r2_cmd_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_active && byte_cnt == '0) |-> !spi_miso);

  // R8: commands other than read never drive data
  a_r8_nonread_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_active && cmd_valid && cmd != CMD_READ) |-> !spi_miso);

endmodule

// File: tb/motor_spi_regs_tb.sv
module motor_spi_regs_tb;

  localparam int NW = 4;
  localparam int NH = 5;
  localparam int ND = NW + 1;
  localparam int H  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso;
  logic [NW*16-1:0] enc;
  logic [6:0] fault;
  logic [7:0] kstat, kvolt;
  logic [NH*8-1:0] hall;
  logic [ND*10-1:0] speed;
  logic [ND*2-1:0] mode;
  logic charge, chip;
  logic [7:0] power;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  int m_speed[ND], m_mode[ND];
  int m_charge = 0, m_chip = 0, m_power = 0, m_err = 0;
  int st_enc[NW], st_hall[NH], st_fault, st_kstat, st_kvolt;
  int exp_rd[19];
  int wr[13];

  always #2.5 clk = ~clk;

  motor_spi_regs u_dut (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_miso(miso), .enc_count(enc), .fault_in(fault), .kick_status(kstat),
    .kick_volt(kvolt), .hall_count(hall), .drv_speed(speed), .drv_mode(mode),
    .kick_charge(charge), .kick_chip(chip), .kick_power(power)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic apply_status(input int seed);
    for (int w = 0; w < NW; w++) begin
      st_enc[w] = (seed * 4099 + w * 7919 + 13) % 65536;
      enc[w*16 +: 16] = st_enc[w][15:0];
    end
    for (int h = 0; h < NH; h++) begin
      st_hall[h] = (seed * 31 + h * 53 + 1) % 256;
      hall[h*8 +: 8] = st_hall[h][7:0];
    end
    st_fault = (seed * 11 + 3) % 128;
    st_kstat = (seed * 17 + 5) % 256;
    st_kvolt = (seed * 23 + 9) % 256;
    fault = st_fault[6:0];
    kstat = st_kstat[7:0];
    kvolt = st_kvolt[7:0];
  endtask

  task automatic build_expected();
    exp_rd[0] = 4;
    for (int w = 0; w < NW; w++) begin
      exp_rd[1 + 2*w] = st_enc[w] % 256;
      exp_rd[2 + 2*w] = st_enc[w] / 256;
    end
    exp_rd[9]  = st_fault + 128 * m_err;
    exp_rd[10] = st_kstat;
    exp_rd[11] = st_kvolt;
    for (int h = 0; h < NH; h++) exp_rd[12 + h] = st_hall[h];
    exp_rd[17] = 0;
    exp_rd[18] = 0;
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int b = 7; b >= 0; b--) begin
      mosi = tx[b];
      repeat (H) @(negedge clk);
      rx[b] = miso;
      sclk = 1'b1;
      repeat (H) @(negedge clk);
      sclk = 1'b0;
    end
  endtask

  task automatic start_txn();
    @(negedge clk);
    cs_n = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic stop_txn();
    repeat (H) @(negedge clk);
    cs_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic check_live(input string tag);
    for (int i = 0; i < ND; i++) begin
      check({tag, " speed"}, 32'(speed[i*10 +: 10]), m_speed[i]);
      check({tag, " mode"}, 32'(mode[i*2 +: 2]), m_mode[i]);
    end
    check({tag, " charge"}, 32'(charge), m_charge);
    check({tag, " chip"}, 32'(chip), m_chip);
    check({tag, " power"}, 32'(power), m_power);
  endtask

  // R2 R3 R4: full read with optional input change after chip-select
  task automatic do_read(input int seed_now, input int seed_later, input bit change);
    logic [7:0] rx;
    apply_status(seed_now);
    build_expected();
    start_txn();
    if (change) begin
      repeat (20) @(negedge clk);
      apply_status(seed_later);
    end
    xfer(8'h00, rx);
    check("R2 command byte quiet", 32'(rx), 0);
    for (int k = 0; k < 19; k++) begin
      xfer(8'(k * 3), rx);
      if (k >= 17) check("R4 tail byte", 32'(rx), exp_rd[k]);
      else if (change) check("R3 snapshot byte", 32'(rx), exp_rd[k]);
      else check("R2 frame byte", 32'(rx), exp_rd[k]);
    end
    stop_txn();
  endtask

  task automatic build_write(input int seed);
    for (int i = 0; i < ND; i++) begin
      int sp, md;
      sp = (seed * 37 + i * 113 + 5) % 1024;
      md = (seed + i) % 4;
      wr[1 + 2*i] = sp % 256;
      wr[2 + 2*i] = sp / 256 + 4 * md;
    end
    wr[10] = wr[10] + 128 * (seed % 2) + 64 * ((seed / 2) % 2);
    wr[11] = (seed * 29 + 7) % 256;
    wr[12] = 8'h5A;
  endtask

  function automatic bit bench_rsvd(input int k, input int b);
    if (k == 10) return ((b / 16) % 4) != 0;
    if (k >= 2 && k <= 8 && (k % 2) == 0) return b >= 16;
    return 0;
  endfunction

  // R5 R6 R7 R8: send command then n data bytes from wr[], update model
  task automatic send_frame(input logic [7:0] cmd, input int n, input string tag);
    logic [7:0] rx;
    bit bad = 0;
    start_txn();
    xfer(cmd, rx);
    check({tag, " R8 miso on command"}, 32'(rx), 0);
    for (int k = 1; k <= n; k++) begin
      xfer(8'(wr[k]), rx);
      check({tag, " R8 miso zero"}, 32'(rx), 0);
    end
    stop_txn();
    if (cmd == 8'h01) begin
      for (int k = 1; k <= n && k <= 11; k++)
        if (bench_rsvd(k, wr[k])) bad = 1;
      if (bad) m_err = 1;
      if (n == 11 && !bad) begin
        for (int i = 0; i < ND; i++) begin
          m_speed[i] = wr[1 + 2*i] + 256 * (wr[2 + 2*i] % 4);
          m_mode[i]  = (wr[2 + 2*i] / 4) % 4;
        end
        m_charge = (wr[10] / 128) % 2;
        m_chip   = (wr[10] / 64) % 2;
        m_power  = wr[11];
      end
    end
    check_live(tag);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    logic [7:0] rx;
    for (int i = 0; i < ND; i++) begin m_speed[i] = 0; m_mode[i] = 0; end
    apply_status(0);
    repeat (10) @(negedge clk);
    check_live("R9 reset");
    check("R9 miso low", 32'(miso), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R2 R4: plain reads across several status patterns; error bit clear
    for (int s = 1; s <= 5; s++) do_read(s, 0, 1'b0);
    // R3: inputs change after chip-select
    do_read(7, 8, 1'b1);

    // R5 R6: well-formed writes
    for (int s = 1; s <= 8; s++) begin
      build_write(s);
      send_frame(8'h01, 11, "R5 R6 full write");
    end

    // R6: short and long frames are dropped
    for (int n = 0; n <= 12; n++) begin
      if (n == 11) continue;
      build_write(100 + n);
      send_frame(8'h01, n, "R6 wrong length");
    end

    // R1: abort mid-byte, then a complete write must land cleanly
    start_txn();
    for (int b = 0; b < 4; b++) begin
      mosi = 1'b1;
      repeat (H) @(negedge clk);
      sclk = 1'b1;
      repeat (H) @(negedge clk);
      sclk = 1'b0;
    end
    stop_txn();
    build_write(50);
    send_frame(8'h01, 11, "R1 after abort");

    // R8: unknown commands
    for (int c = 2; c <= 17; c++) begin
      logic [7:0] code;
      code = (c == 16) ? 8'h80 : (c == 17) ? 8'hFF : 8'(c);
      build_write(200 + c);
      send_frame(code, 11, "R8 unknown command");
    end
    do_read(9, 0, 1'b0);

    // R7: each reserved field in turn
    for (int p = 0; p < 6; p++) begin
      build_write(300 + p);
      case (p)
        0: wr[2]  = wr[2]  + 16;
        1: wr[4]  = wr[4]  + 32;
        2: wr[6]  = wr[6]  + 64;
        3: wr[8]  = wr[8]  + 128;
        4: wr[10] = wr[10] + 16;
        default: wr[10] = wr[10] + 32;
      endcase
      send_frame(8'h01, 11, "R7 reserved violation");
    end
    do_read(10, 0, 1'b0);
    // R7: flag stays set after a clean write
    build_write(60);
    send_frame(8'h01, 11, "R7 clean write after error");
    do_read(11, 0, 1'b0);

    finished = 1;
    summary();
  end

endmodule